// File: doc/BRIEF.md
# Display PLL Post-Divider Clock Tree

This block sits behind a display PLL's VCO and derives the two clocks that a serial display link needs. A pixel clock comes straight off the VCO through a wide programmable divider. A byte clock comes off a two-way path: either the VCO itself or a narrow programmable divider followed by a fixed halving stage. That choice then always passes through a fixed divide-by-four.

All counting is done with registers clocked by the VCO clock. The programmed settings are sampled only at the end of an output period, so changing a field or the path select never produces a runt pulse. A field value N gives a divide ratio of N+1. For the pixel output a value of zero passes the VCO clock straight through.

Top module: `pll_postdiv_tree`

## Requirements
- R1: While `rst_n` is low, `byte_clk` and `pix_clk` are low. Asserting `rst_n` forces both low at once, without waiting for a clock edge.
- R2: With `pix_div_cfg` = N, `pix_clk` has a period of N+1 VCO cycles. With N = 0, `pix_clk` equals the VCO clock, with a period of one cycle and a high time of half a cycle.
- R3: For an even ratio N+1, `pix_clk` is high for exactly half the period. For an odd ratio above 1, it is high for (N+2)/2 cycles, which is one VCO cycle more than its low time.
- R4: With `byte_path_sel` = 0 (raw VCO path), `byte_clk` has a period of 4 VCO cycles and is high for 2 of them, whatever the value of `pre_div_cfg`.
- R5: With `byte_path_sel` = 1 (divided path), `byte_clk` has a period of 8·(P+1) VCO cycles for `pre_div_cfg` = P, with a 50% duty cycle.
- R6: A change of `pix_div_cfg` takes effect at the end of the current `pix_clk` period. No high or low phase is shorter than the shorter phase of the old and new settings.
- R7: A change of `byte_path_sel` or `pre_div_cfg` takes effect only at period boundaries. No `byte_clk` phase is ever shorter than 2 VCO cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | High-rate VCO clock; clocks every register |
| rst_n | input | 1 | Asynchronous reset, active low |
| pre_div_cfg | input | PRE_W (4) | Byte-path pre-divider setting; ratio = value + 1 |
| pix_div_cfg | input | PIX_W (8) | Pixel divider setting; ratio = value + 1, 0 = pass-through |
| byte_path_sel | input | 1 | 0: byte path from raw VCO; 1: from pre-divider plus halving stage |
| byte_clk | output | 1 | Byte clock |
| pix_clk | output | 1 | Pixel clock |

## Verification
The pixel divider is measured at five settings:
- pass-through, which separates a combinational bypass from a registered divide;
- ratio 2 and a mid-range odd ratio, which show whether the odd high phase gets the extra cycle;
- the largest ratio, which exposes counter-width faults.

The byte clock is measured with the raw path under two different pre-divider settings, which proves the pre-divider has no effect on that path. It is also measured with the divided path under three pre-divider values, which separates the halving and divide-by-four factors from the programmable one.

Repeated field and path changes at shifting cycle offsets, made while every output edge is timed, show whether any switch slips in a pulse shorter than the settings allow. An asynchronous reset made in the middle of a run shows whether the outputs drop without waiting for a clock edge.

// File: rtl/pll_postdiv_tree.sv
module pll_postdiv_tree #(
  parameter int PRE_W    = 4,
  parameter int PIX_W    = 8,
  parameter int BYTE_LOG = 2
) (
  input  logic             vco_clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] pre_div_cfg,
  input  logic [PIX_W-1:0] pix_div_cfg,
  input  logic             byte_path_sel,
  output logic             byte_clk,
  output logic             pix_clk
);

  localparam int HW = PIX_W + 1;

  // byte path: programmable pre-divider, halving stage, fixed divide-by-4
  logic [PRE_W-1:0]    pre_cnt, pre_cur;
  logic                pre_tick, half_q;
  logic                sel_cur, sel_edge, byte_q;
  logic [BYTE_LOG-1:0] bcnt, bcnt_nx;

  assign pre_tick = (pre_cnt == pre_cur);
  assign sel_edge = sel_cur ? (pre_tick & ~half_q) : 1'b1;
  assign bcnt_nx  = bcnt + BYTE_LOG'(1);

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      pre_cur <= '0;
      half_q  <= 1'b0;
    end else if (pre_tick) begin
      pre_cnt <= '0;
      pre_cur <= pre_div_cfg;
      half_q  <= ~half_q;
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt    <= '1;
      byte_q  <= 1'b0;
      sel_cur <= 1'b0;
    end else if (sel_edge) begin
      bcnt   <= bcnt_nx;
      byte_q <= ~bcnt_nx[BYTE_LOG-1];
      if (&bcnt) sel_cur <= byte_path_sel;
    end
  end

  assign byte_clk = byte_q;

  // pixel path: wide programmable divider with pass-through at zero
  logic [PIX_W-1:0] pix_cnt, pix_cur;
  logic [HW-1:0]    pix_hi, pix_nx;
  logic             pix_tick, pix_q, run;

  assign pix_tick = (pix_cnt == pix_cur);
  assign pix_hi   = ({1'b0, pix_cur} + HW'(2)) >> 1;
  assign pix_nx   = {1'b0, pix_cnt} + HW'(1);

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt <= '0;
      pix_cur <= '0;
      pix_q   <= 1'b0;
      run     <= 1'b0;
    end else begin
      run <= 1'b1;
      if (pix_tick) begin
        pix_cnt <= '0;
        pix_cur <= pix_div_cfg;
        pix_q   <= 1'b1;
      end else begin
        pix_cnt <= pix_nx[PIX_W-1:0];
        pix_q   <= (pix_nx < pix_hi);
      end
    end
  end

  assign pix_clk = run & ((pix_cur == '0) ? vco_clk : pix_q);

endmodule

// File: rtl/pll_postdiv_tree_chk.sv
module pll_postdiv_tree_chk #(
  parameter int PRE_W = 4,
  parameter int PIX_W = 8
) (
  input logic             vco_clk,
  input logic             rst_n,
  input logic [PIX_W-1:0] pix_div_cfg,
  input logic             byte_path_sel,
  input logic             byte_clk,
  input logic             pix_clk
);

  localparam int SEL_LIM = 8 * (2 ** PRE_W) + 8;
  localparam int PIX_LIM = (2 ** PIX_W) + 4;

  int   sel_same, pix_same, blen;
  logic bprev, seen;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_same <= 0;
      pix_same <= 0;
      blen     <= 0;
      bprev    <= 1'b0;
      seen     <= 1'b0;
    end else begin
      if (byte_path_sel) sel_same <= 0;
      else if (sel_same < SEL_LIM) sel_same <= sel_same + 1;
      if (pix_div_cfg != PIX_W'(1)) pix_same <= 0;
      else if (pix_same < PIX_LIM) pix_same <= pix_same + 1;
      bprev <= byte_clk;
      if (byte_clk != bprev) begin
        blen <= 1;
        seen <= 1'b1;
      end else if (blen < 1000) begin
        blen <= blen + 1;
      end
    end
  end

  always @(negedge vco_clk)
    if (rst_n === 1'b0)
      a_r1_low_in_reset: assert (byte_clk === 1'b0 && pix_clk === 1'b0)
        else $error("outputs not low in reset");

  a_r7_byte_min_phase: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (seen && byte_clk != bprev) |-> (blen >= 2));

  a_r4_byte_raw_div4: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (!byte_path_sel && sel_same >= SEL_LIM) |-> (byte_clk != $past(byte_clk, 2)));

  a_r2_pix_ratio_two: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (pix_div_cfg == PIX_W'(1) && pix_same >= PIX_LIM) |-> (pix_clk != $past(pix_clk)));

endmodule

bind pll_postdiv_tree pll_postdiv_tree_chk #(.PRE_W(PRE_W), .PIX_W(PIX_W)) u_chk (
  .vco_clk(vco_clk), .rst_n(rst_n), .pix_div_cfg(pix_div_cfg),
  .byte_path_sel(byte_path_sel), .byte_clk(byte_clk), .pix_clk(pix_clk)
);

// File: tb/sim_pll_postdiv_tree.sv
`timescale 1ns/1ps
module sim_pll_postdiv_tree;
  logic       vco_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [3:0] pre_div_cfg = 4'd0;
  logic [7:0] pix_div_cfg = 8'd0;
  logic       byte_path_sel = 1'b0;
  logic       byte_clk, pix_clk;

  int  checks = 0, errors = 0;
  bit  done = 0;
  bit  mon_pix = 0, mon_byte = 0;
  realtime pix_last = 0, byte_last = 0, pix_min = 1.0e9, byte_min = 1.0e9;

  always #10 vco_clk = ~vco_clk;

  pll_postdiv_tree u0 (
    .vco_clk(vco_clk), .rst_n(rst_n), .pre_div_cfg(pre_div_cfg),
    .pix_div_cfg(pix_div_cfg), .byte_path_sel(byte_path_sel),
    .byte_clk(byte_clk), .pix_clk(pix_clk)
  );

  always @(pix_clk) begin
    if (mon_pix && ($realtime - pix_last) < pix_min) pix_min = $realtime - pix_last;
    pix_last = $realtime;
  end

  always @(byte_clk) begin
    if (mon_byte && ($realtime - byte_last) < byte_min) byte_min = $realtime - byte_last;
    byte_last = $realtime;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge vco_clk);
  endtask

  // results in half VCO cycles (10 ns)
  task automatic meas(input bit pix, output int hi_h, output int per_h);
    realtime t0, t1, t2;
    if (pix) begin
      @(posedge pix_clk); t0 = $realtime;
      @(negedge pix_clk); t1 = $realtime;
      @(posedge pix_clk); t2 = $realtime;
    end else begin
      @(posedge byte_clk); t0 = $realtime;
      @(negedge byte_clk); t1 = $realtime;
      @(posedge byte_clk); t2 = $realtime;
    end
    hi_h  = int'((t1 - t0) / 10.0);
    per_h = int'((t2 - t0) / 10.0);
  endtask

  task automatic test_reset();
    settle(5);
    chk("R1 byte low in reset", int'(byte_clk), 0);
    chk("R1 pix low in reset", int'(pix_clk), 0);
    rst_n = 1'b1;
    settle(700);
    #3 rst_n = 1'b0;
    #1;
    chk("R1 byte low on async reset", int'(byte_clk), 0);
    chk("R1 pix low on async reset", int'(pix_clk), 0);
    settle(4);
    rst_n = 1'b1;
  endtask

  task automatic test_pix(input int n);
    int hi, per;
    @(negedge vco_clk) pix_div_cfg = 8'(n);
    settle(700);
    meas(1'b1, hi, per);
    chk($sformatf("R2 pix period N=%0d", n), per, 2 * (n + 1));
    chk($sformatf("R3 pix high N=%0d", n), hi, (n == 0) ? 1 : 2 * ((n + 2) / 2));
  endtask

  task automatic test_byte(input bit sel, input int p);
    int hi, per;
    @(negedge vco_clk);
    byte_path_sel = sel;
    pre_div_cfg   = 4'(p);
    settle(700);
    meas(1'b0, hi, per);
    if (!sel) begin
      chk($sformatf("R4 byte period P=%0d", p), per, 8);
      chk($sformatf("R4 byte high P=%0d", p), hi, 4);
    end else begin
      chk($sformatf("R5 byte period P=%0d", p), per, 16 * (p + 1));
      chk($sformatf("R5 byte high P=%0d", p), hi, 8 * (p + 1));
    end
  endtask

  task automatic test_pix_switch();
    @(negedge vco_clk) pix_div_cfg = 8'd1;
    settle(700);
    pix_min = 1.0e9; mon_pix = 1;
    for (int i = 0; i < 24; i++) begin
      pix_div_cfg = (i % 2 == 0) ? 8'd7 : 8'd1;
      settle(3 + i);
    end
    settle(40);
    mon_pix = 0;
    chk("R6 pix min phase ns (ratio 2 and 8)", int'(pix_min), 20);
    pix_min = 1.0e9; mon_pix = 1;
    for (int i = 0; i < 20; i++) begin
      pix_div_cfg = (i % 2 == 0) ? 8'd3 : 8'd0;
      settle(2 + i);
    end
    settle(20);
    mon_pix = 0;
    chk("R6 pix min phase ns (bypass and ratio 4)", int'(pix_min), 10);
  endtask

  task automatic test_byte_switch();
    @(negedge vco_clk);
    byte_path_sel = 1'b0; pre_div_cfg = 4'd0;
    settle(700);
    byte_min = 1.0e9; mon_byte = 1;
    for (int i = 0; i < 24; i++) begin
      byte_path_sel = ~byte_path_sel;
      if (i % 3 == 0) pre_div_cfg = 4'(i % 4);
      settle(5 + 3 * i);
    end
    settle(200);
    mon_byte = 0;
    chk("R7 byte min phase ns", int'(byte_min), 40);
  endtask

  task automatic finish_up();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    test_reset();
    test_pix(0);
    test_pix(1);
    test_pix(2);
    test_pix(4);
    test_pix(255);
    test_byte(1'b0, 0);
    test_byte(1'b0, 5);
    test_byte(1'b1, 0);
    test_byte(1'b1, 2);
    test_byte(1'b1, 15);
    test_pix_switch();
    test_byte_switch();
    finish_up();
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_up();
    end
  end
endmodule